// File: doc/BRIEF.md
# PAL Composite Timing and Pattern Generator

This block produces a progressive PAL-style composite frame as an 8-bit code for an external resistor DAC. The upper nibble of the code selects the colour phase and the lower nibble sets the luma level. A single fast clock drives it, and every timing interval is a whole number of clock cycles. At the default 80 MHz clock one cycle is 12.5 ns.

Each scanline is built from a cycle position counter. The line begins with a blanking lead-in made of black, sync, a short black gap, a burst interval and more black. The rest of the line is the picture region. A region counter sets the order of lines in a frame: picture lines first, then lower border lines, then full-sync lines, then upper border lines, and then the frame repeats.

On picture lines the block draws a solid rectangle in a configurable colour. Its line window and column window are also configurable. All of these settings are captured only at reset and at each frame boundary. The block also drives separate line-sync, frame-sync and picture-active strobes.

Top module: `pal_pattern_gen`

## Requirements
- R1: While the synchronous active-high reset is held, and in the first cycle after it is released, the block is at cycle 0 of the first picture line. In that state the video code is black (0xF6) and hsync, vsync and active are all low.
- R2: Every line lasts exactly LINE_LEN cycles, 5120 by default. Lines that are not frame-sync lines start with these intervals in this order: black (0xF6) for FP_LEN cycles, sync (0xF0) for SYNC_LEN, black for BRZ_LEN, burst (0x06) for BURST_LEN, and black for BACK_LEN. The remaining cycles form the picture region.
- R3: hsync is high exactly during the sync interval of lines that are not frame-sync lines, and the code is 0xF0 at that time.
- R4: A frame is ACT_LINES picture lines, then BOT_LINES lower border lines, then VS_LINES frame-sync lines, then TOP_LINES upper border lines, and then the sequence repeats.
- R5: During a frame-sync line the code is 0xF0 for the whole line and vsync is high. hsync and active are low, and there are no porch or burst intervals.
- R6: Picture lines are numbered downward, from ACT_LINES on the first picture line to 1 on the last. On a picture line whose number lies in [line_lo, line_hi], the code is the rectangle colour at offsets [col_start, col_start+col_width) of the picture region. Everywhere else in the picture region it is black (0xF6).
- R7: In the picture region of border lines the code is black, with no rectangle, and active is low.
- R8: active is high exactly in the picture region of picture lines.
- R9: The rectangle settings are captured only during reset and at the cycle where a new frame begins. A change in the middle of a frame takes effect from the next frame.
- R10: The rectangle is cut off at the end of the line and never spreads into the next line's blanking. A width of 0 draws no rectangle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| rect_line_lo | input | LW | Lowest line number of the rectangle |
| rect_line_hi | input | LW | Highest line number of the rectangle |
| rect_col_start | input | HW | First picture-region offset of the rectangle |
| rect_col_width | input | HW | Rectangle width in cycles |
| rect_code | input | 8 | Rectangle colour/luma code |
| video_o | output | 8 | Colour nibble (7:4) and luma nibble (3:0) to the DAC |
| hsync_o | output | 1 | High during the line-sync interval |
| vsync_o | output | 1 | High during frame-sync lines |
| active_o | output | 1 | High during the picture region of picture lines |

## Verification
The assertions check the following on every cycle:
- Frame-sync lines carry the sync code with hsync low.
- hsync always coincides with the sync code.
- active never overlaps either sync strobe.
- The distance between consecutive hsync rises is exactly one line, except where frame-sync lines fall between them.
- The state right after reset is black with all strobes low.

Some behaviours can only be shown by the bench scenarios:
- The exact placement of every interval and every rectangle pixel.
- The line count of each frame region.
- Deferral of mid-frame setting changes to the next frame.
- Clipping at the end of the line.
- The empty rectangle.

The bench covers these by comparing every output on every cycle against an arithmetic model, over several frames of a reduced configuration.

// File: rtl/pal_pattern_gen.sv
module pal_pattern_gen #(
  parameter int FP_LEN    = 120,
  parameter int SYNC_LEN  = 376,
  parameter int BRZ_LEN   = 48,
  parameter int BURST_LEN = 200,
  parameter int BACK_LEN  = 128,
  parameter int LINE_LEN  = 5120,
  parameter int ACT_LINES = 206,
  parameter int BOT_LINES = 50,
  parameter int VS_LINES  = 5,
  parameter int TOP_LINES = 50,
  parameter logic [7:0] CODE_SYNC  = 8'hF0,
  parameter logic [7:0] CODE_BLACK = 8'hF6,
  parameter logic [7:0] CODE_BURST = 8'h06,
  localparam int MAXL_A = (ACT_LINES > BOT_LINES) ? ACT_LINES : BOT_LINES,
  localparam int MAXL_B = (VS_LINES > TOP_LINES) ? VS_LINES : TOP_LINES,
  localparam int MAXL   = (MAXL_A > MAXL_B) ? MAXL_A : MAXL_B,
  localparam int LW     = $clog2(MAXL + 1),
  localparam int HW     = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] rect_line_lo,
  input  logic [LW-1:0] rect_line_hi,
  input  logic [HW-1:0] rect_col_start,
  input  logic [HW-1:0] rect_col_width,
  input  logic [7:0]    rect_code,
  output logic [7:0]    video_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          active_o
);
  localparam int SYNC_AT  = FP_LEN;
  localparam int BRZ_AT   = SYNC_AT + SYNC_LEN;
  localparam int BURST_AT = BRZ_AT + BRZ_LEN;
  localparam int BACK_AT  = BURST_AT + BURST_LEN;
  localparam int PIX_AT   = BACK_AT + BACK_LEN;

  typedef enum logic [1:0] {RG_ACT, RG_BOT, RG_VS, RG_TOP} region_t;

  region_t       region;
  logic [HW-1:0] hpos;
  logic [LW-1:0] lines_left;
  logic [LW-1:0] c_lo, c_hi;
  logic [HW-1:0] c_start, c_width;
  logic [7:0]    c_code;

  wire line_end   = hpos == HW'(LINE_LEN - 1);
  wire region_end = line_end && lines_left == LW'(1);
  wire frame_end  = region_end && region == RG_TOP;

  function automatic logic [LW-1:0] region_lines(region_t r);
    case (r)
      RG_ACT:  return LW'(ACT_LINES);
      RG_BOT:  return LW'(BOT_LINES);
      RG_VS:   return LW'(VS_LINES);
      default: return LW'(TOP_LINES);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos       <= '0;
      region     <= RG_ACT;
      lines_left <= LW'(ACT_LINES);
    end else begin
      hpos <= line_end ? '0 : hpos + HW'(1);
      if (region_end) begin
        region     <= region_t'(region + 2'd1);
        lines_left <= region_lines(region_t'(region + 2'd1));
      end else if (line_end) begin
        lines_left <= lines_left - LW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      c_lo    <= rect_line_lo;
      c_hi    <= rect_line_hi;
      c_start <= rect_col_start;
      c_width <= rect_col_width;
      c_code  <= rect_code;
    end
  end

  wire in_sync  = hpos >= HW'(SYNC_AT)  && hpos < HW'(BRZ_AT);
  wire in_burst = hpos >= HW'(BURST_AT) && hpos < HW'(BACK_AT);
  wire in_pix   = hpos >= HW'(PIX_AT);

  wire [HW:0] pix_pos = {1'b0, hpos} - (HW+1)'(PIX_AT);
  wire [HW:0] col_end = {1'b0, c_start} + {1'b0, c_width};
  wire on_line = region == RG_ACT && lines_left >= c_lo && lines_left <= c_hi;
  wire in_rect = on_line && in_pix && pix_pos >= {1'b0, c_start} && pix_pos < col_end;

  always_comb begin
    if (region == RG_VS)  video_o = CODE_SYNC;
    else if (in_sync)     video_o = CODE_SYNC;
    else if (in_burst)    video_o = CODE_BURST;
    else if (in_rect)     video_o = c_code;
    else                  video_o = CODE_BLACK;
  end

  assign vsync_o  = region == RG_VS;
  assign hsync_o  = region != RG_VS && in_sync;
  assign active_o = region == RG_ACT && in_pix;
endmodule

// File: rtl/pal_pattern_chk.sv
module pal_pattern_chk #(
  parameter int LINE_LEN = 5120,
  parameter logic [7:0] CODE_SYNC  = 8'hF0,
  parameter logic [7:0] CODE_BLACK = 8'hF6
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] video_o,
  input logic       hsync_o,
  input logic       vsync_o,
  input logic       active_o
);
  logic [31:0] gap;
  logic        armed, vs_between, hs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '0; armed <= 1'b0; vs_between <= 1'b0; hs_q <= 1'b0;
    end else begin
      hs_q <= hsync_o;
      if (hsync_o && !hs_q) begin
        gap <= 32'd1; armed <= 1'b1; vs_between <= 1'b0;
      end else begin
        gap <= gap + 32'd1;
        if (vsync_o) vs_between <= 1'b1;
      end
    end
  end

  // R5
  vsync_code_chk: assert property (@(posedge clk) disable iff (rst)
    vsync_o |-> (video_o == CODE_SYNC && !hsync_o && !active_o));

  // R3
  hsync_code_chk: assert property (@(posedge clk) disable iff (rst)
    hsync_o |-> video_o == CODE_SYNC);

  // R8
  active_excl_chk: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (!hsync_o && !vsync_o));

  // R2
  line_len_chk: assert property (@(posedge clk) disable iff (rst)
    (hsync_o && !hs_q && armed && !vs_between) |-> gap == LINE_LEN);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (video_o == CODE_BLACK && !hsync_o && !vsync_o && !active_o));
endmodule

bind pal_pattern_gen pal_pattern_chk #(
  .LINE_LEN(LINE_LEN), .CODE_SYNC(CODE_SYNC), .CODE_BLACK(CODE_BLACK)
) u_chk (
  .clk(clk), .rst(rst), .video_o(video_o), .hsync_o(hsync_o),
  .vsync_o(vsync_o), .active_o(active_o)
);

// File: tb/pal_pattern_gen_bench.sv
module pal_pattern_gen_bench;
  localparam int FP = 3, SY = 5, BZ = 2, BU = 4, BK = 3, L = 40;
  localparam int ACT = 8, BOT = 3, VS = 2, TOP = 3;
  localparam int PIX = FP + SY + BZ + BU + BK;
  localparam int FRAME = (ACT + BOT + VS + TOP) * L;
  localparam int LW = 4, HW = 6;

  logic clk = 0, rst = 1;
  logic [LW-1:0] lo, hi;
  logic [HW-1:0] st, wd;
  logic [7:0] rc;
  logic [7:0] video;
  logic hs, vs, av;

  int tests = 0, fails = 0;
  bit done = 0;
  int e_lo, e_hi, e_st, e_wd;
  logic [7:0] e_rc;

  always #5 clk = ~clk;

  pal_pattern_gen #(
    .FP_LEN(FP), .SYNC_LEN(SY), .BRZ_LEN(BZ), .BURST_LEN(BU), .BACK_LEN(BK),
    .LINE_LEN(L), .ACT_LINES(ACT), .BOT_LINES(BOT), .VS_LINES(VS), .TOP_LINES(TOP)
  ) u_pal_pattern_gen (
    .clk(clk), .rst(rst), .rect_line_lo(lo), .rect_line_hi(hi),
    .rect_col_start(st), .rect_col_width(wd), .rect_code(rc),
    .video_o(video), .hsync_o(hs), .vsync_o(vs), .active_o(av)
  );

  task automatic latch_cfg();
    e_lo = lo; e_hi = hi; e_st = st; e_wd = wd; e_rc = rc;
  endtask

  task automatic check_reset();
    tests++;
    if (video !== 8'hF6 || hs !== 0 || vs !== 0 || av !== 0) begin
      fails++;
      $display("FAIL R1 reset: video=%h hs=%b vs=%b av=%b exp video=f6 hs=0 vs=0 av=0",
               video, hs, vs, av);
    end
  endtask

  task automatic check_cycle(int t);
    int f, ln, h, rg, cnt, frm;
    logic [7:0] ec;
    logic eh, ev, ea, rect;
    string tag;
    if (t % FRAME == 0) latch_cfg();
    frm = t / FRAME; f = t % FRAME; ln = f / L; h = f % L; cnt = 0;
    if (ln < ACT) begin rg = 0; cnt = ACT - ln; end
    else if (ln < ACT + BOT) rg = 1;
    else if (ln < ACT + BOT + VS) rg = 2;
    else rg = 3;
    rect = 0;
    if (rg == 2) begin
      ec = 8'hF0; eh = 0; ev = 1; ea = 0; tag = "R5";
    end else begin
      ev = 0;
      eh = (h >= FP && h < FP + SY);
      ea = (rg == 0 && h >= PIX);
      if (h < FP) ec = 8'hF6;
      else if (h < FP + SY) ec = 8'hF0;
      else if (h < FP + SY + BZ) ec = 8'hF6;
      else if (h < FP + SY + BZ + BU) ec = 8'h06;
      else if (h < PIX) ec = 8'hF6;
      else begin
        rect = rg == 0 && cnt >= e_lo && cnt <= e_hi &&
               (h - PIX) >= e_st && (h - PIX) < e_st + e_wd;
        ec = rect ? e_rc : 8'hF6;
      end
      if (eh) tag = "R3";
      else if (h < PIX) tag = (rg != 0 && h < FP) ? "R4" : "R2";
      else if (rg != 0) tag = "R7";
      else if (frm >= 3) tag = "R10";
      else if (frm >= 1) tag = "R9";
      else tag = rect ? "R6" : "R8";
    end
    tests++;
    if (video !== ec || hs !== eh || vs !== ev || av !== ea) begin
      fails++;
      $display("FAIL %s t=%0d line=%0d h=%0d: video=%h hs=%b vs=%b av=%b exp video=%h hs=%b vs=%b av=%b",
               tag, t, ln, h, video, hs, vs, av, ec, eh, ev, ea);
    end
  endtask

  initial begin
    lo = 4'd3; hi = 4'd5; st = 6'd4; wd = 6'd6; rc = 8'h1F;
    repeat (3) @(negedge clk);
    check_reset();
    rst = 0;
    for (int t = 0; t < 4 * FRAME + 10; t++) begin
      check_cycle(t);
      // R9: mid-frame changes, effective next frame
      if (t == 100) begin lo = 4'd6; hi = 4'd7; st = 6'd0; wd = 6'd23; rc = 8'h5A; end
      // R10: empty rectangle
      if (t == FRAME + 50) wd = 6'd0;
      // R10: clipped at end of line, full line window
      if (t == 2 * FRAME + 70) begin lo = 4'd1; hi = 4'd8; st = 6'd20; wd = 6'd10; rc = 8'h3C; end
      @(negedge clk);
    end
    // R1: reset in mid-frame restarts the frame
    rst = 1;
    lo = 4'd8; hi = 4'd8; st = 6'd1; wd = 6'd2; rc = 8'h77;
    repeat (2) @(negedge clk);
    check_reset();
    rst = 0;
    for (int t = 0; t < FRAME; t++) begin
      check_cycle(t);
      @(negedge clk);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule